// File: doc/BRIEF.md
# Shared Tag Port Arbiter with Snoop Retry and Castout Escalation

This block sits in front of a single-ported cache tag array that three requesters share: processor load/store lookups, bus snoop lookups and tag writes (for example, marking a line valid once its fill completes). Each clock it picks one requester for the tag port. It answers every snoop with a one-cycle grant or a one-cycle retry, and it raises a stall to the processor side when the processor request loses.

The block also holds a one-entry copy-back buffer. This buffer keeps a modified block that is waiting to be written back to memory. The block orders bus requests between that castout and the outstanding block fill. If a snoop hits the block in the buffer, the snoop is retried and the castout becomes urgent, so it goes to the bus ahead of the fill. The tag RAM and the bus appear only as simple request and issue signals. All outputs are registered: the response to the inputs of a cycle appears after the next rising edge.

Top module: `tag_port_arbiter`

## Requirements
- R1: A snoop that meets no retry condition wins the port over a processor request. It produces snp_grant=1 and port_owner=2 (snoop), with tag_addr equal to the snoop address, and the processor request gets cpu_stall=1.
- R2: A processor request that was stalled in the previous cycle gets the port (port_owner=3) if no tag write is present, even when a snoop arrives. That snoop is retried.
- R3: A tag write takes the port (port_owner=1, tag_we=1, tag_addr = write address). A snoop in the same cycle is retried.
- R4: A snoop that arrives while burst_busy=1 is retried. A processor request in the same cycle is still served.
- R5: A snoop whose block number (address bits above BLK_OFF) equals the block held in a valid copy-back buffer is retried, and cob_urgent becomes 1.
- R6: When bus_ready=1, at most one bus issue happens per cycle. The order is: urgent castout first, then the pending fill, then a normal castout. A castout issue empties the buffer and clears urgency.
- R7: A tag write beats a processor request in the same cycle, and the processor side sees cpu_stall=1.
- R8: snp_grant and snp_retry are never both 1. Each is a single-cycle pulse per snoop cycle. A retry leaves no state behind, so the same snoop is granted once the condition has cleared.
- R9: After reset, all outputs are 0 and port_owner=0 (idle).
- R10: cob_load fills the buffer (cob_full=1). A snoop to a different block is not a collision and is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor load/store lookup request |
| cpu_addr | input | ADDR_W | Processor lookup address |
| snp_req | input | 1 | Bus snoop lookup request |
| snp_addr | input | ADDR_W | Snoop address |
| twr_req | input | 1 | Tag write request |
| twr_addr | input | ADDR_W | Tag write address |
| burst_busy | input | 1 | Cache busy with a burst read or write |
| cob_load | input | 1 | Load a modified block into the copy-back buffer |
| cob_blk | input | ADDR_W-BLK_OFF | Block number being loaded |
| fill_pend | input | 1 | A block fill is waiting for the bus |
| bus_ready | input | 1 | Bus can accept one request this cycle |
| tag_en | output | 1 | Tag port access this cycle |
| tag_we | output | 1 | Tag port access is a write |
| tag_addr | output | ADDR_W | Tag port address |
| port_owner | output | 2 | 0 idle, 1 write, 2 snoop, 3 processor |
| snp_grant | output | 1 | Snoop granted pulse |
| snp_retry | output | 1 | Snoop retry pulse |
| cpu_stall | output | 1 | Processor request not served |
| cob_full | output | 1 | Copy-back buffer holds a block |
| cob_urgent | output | 1 | Buffered castout has been escalated |
| co_issue | output | 1 | Castout issued to bus |
| fill_issue | output | 1 | Fill issued to bus |

## Verification
The assertions assume that cob_load is raised only while the buffer is empty and that fill_pend stays high until fill_issue has pulsed. They also assume each request input is steady for a whole clock period. The directed stimulus changes inputs just after each rising edge. It loads the buffer only after the previous castout has issued and drops fill_pend in the cycle after the fill issues, so no assertion sees input combinations outside these limits.

// File: rtl/tpa_pkg.sv
package tpa_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE  = 2'd0,
    OWN_WRITE = 2'd1,
    OWN_SNOOP = 2'd2,
    OWN_CPU   = 2'd3
  } owner_e;
endpackage

// File: rtl/tpa_snoop_check.sv
module tpa_snoop_check #(
  parameter int BLK_W = 27
) (
  input  logic             snp_req,
  input  logic [BLK_W-1:0] snp_blk,
  input  logic             twr_req,
  input  logic             burst_busy,
  input  logic             cpu_owed,
  input  logic             cob_valid,
  input  logic [BLK_W-1:0] cob_blk_q,
  output logic             snp_ok,
  output logic             snp_rej,
  output logic             collide
);
  logic blocked;

  always_comb begin
    collide = snp_req && cob_valid && (snp_blk == cob_blk_q);
    blocked = twr_req || burst_busy || cpu_owed || collide;
    snp_ok  = snp_req && !blocked;
    snp_rej = snp_req && blocked;
  end
endmodule

// File: rtl/tpa_port_select.sv
module tpa_port_select
  import tpa_pkg::*;
(
  input  logic   twr_req,
  input  logic   snp_ok,
  input  logic   cpu_req,
  output owner_e owner,
  output logic   cpu_win
);
  always_comb begin
    if (twr_req)      owner = OWN_WRITE;
    else if (snp_ok)  owner = OWN_SNOOP;
    else if (cpu_req) owner = OWN_CPU;
    else              owner = OWN_IDLE;
    cpu_win = (owner == OWN_CPU);
  end
endmodule

// File: rtl/tpa_castout_buf.sv
module tpa_castout_buf #(
  parameter int BLK_W = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cob_load,
  input  logic [BLK_W-1:0] cob_blk,
  input  logic             collide,
  input  logic             bus_ready,
  input  logic             fill_pend,
  output logic             cob_valid,
  output logic [BLK_W-1:0] cob_blk_q,
  output logic             cob_hot,
  output logic             co_go,
  output logic             fill_go
);
  always_comb begin
    co_go   = bus_ready && cob_valid && (cob_hot || !fill_pend);
    fill_go = bus_ready && fill_pend && !(cob_valid && cob_hot);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cob_valid <= 1'b0;
      cob_hot   <= 1'b0;
      cob_blk_q <= '0;
    end else begin
      if (co_go) begin
        cob_valid <= 1'b0;
        cob_hot   <= 1'b0;
      end else if (cob_load && !cob_valid) begin
        cob_valid <= 1'b1;
        cob_blk_q <= cob_blk;
      end else if (collide) begin
        cob_hot <= 1'b1;
      end
    end
  end

  // R6: an escalated castout must never let the fill go first
  a_r6_urgent_first: assert property (@(posedge clk) disable iff (rst)
    (cob_valid && cob_hot && bus_ready) |-> (co_go && !fill_go));
endmodule

// File: rtl/tag_port_arbiter.sv
module tag_port_arbiter
  import tpa_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BLK_OFF = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cpu_req,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic                      snp_req,
  input  logic [ADDR_W-1:0]         snp_addr,
  input  logic                      twr_req,
  input  logic [ADDR_W-1:0]         twr_addr,
  input  logic                      burst_busy,
  input  logic                      cob_load,
  input  logic [ADDR_W-BLK_OFF-1:0] cob_blk,
  input  logic                      fill_pend,
  input  logic                      bus_ready,
  output logic                      tag_en,
  output logic                      tag_we,
  output logic [ADDR_W-1:0]         tag_addr,
  output logic [1:0]                port_owner,
  output logic                      snp_grant,
  output logic                      snp_retry,
  output logic                      cpu_stall,
  output logic                      cob_full,
  output logic                      cob_urgent,
  output logic                      co_issue,
  output logic                      fill_issue
);
  localparam int BLK_W = ADDR_W - BLK_OFF;

  logic             snp_ok, snp_rej, collide, cpu_win;
  logic             cob_valid, cob_hot, co_go, fill_go;
  logic [BLK_W-1:0] cob_blk_q;
  owner_e           owner;
  logic [ADDR_W-1:0] addr_n;

  tpa_snoop_check #(.BLK_W(BLK_W)) u_chk (
    .snp_req(snp_req), .snp_blk(snp_addr[ADDR_W-1:BLK_OFF]),
    .twr_req(twr_req), .burst_busy(burst_busy),
    .cpu_owed(cpu_stall && cpu_req),
    .cob_valid(cob_valid), .cob_blk_q(cob_blk_q),
    .snp_ok(snp_ok), .snp_rej(snp_rej), .collide(collide)
  );

  tpa_port_select u_sel (
    .twr_req(twr_req), .snp_ok(snp_ok), .cpu_req(cpu_req),
    .owner(owner), .cpu_win(cpu_win)
  );

  tpa_castout_buf #(.BLK_W(BLK_W)) u_cob (
    .clk(clk), .rst(rst), .cob_load(cob_load), .cob_blk(cob_blk),
    .collide(collide), .bus_ready(bus_ready), .fill_pend(fill_pend),
    .cob_valid(cob_valid), .cob_blk_q(cob_blk_q), .cob_hot(cob_hot),
    .co_go(co_go), .fill_go(fill_go)
  );

  always_comb begin
    case (owner)
      OWN_WRITE: addr_n = twr_addr;
      OWN_SNOOP: addr_n = snp_addr;
      OWN_CPU:   addr_n = cpu_addr;
      default:   addr_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_en     <= 1'b0;
      tag_we     <= 1'b0;
      tag_addr   <= '0;
      port_owner <= OWN_IDLE;
      snp_grant  <= 1'b0;
      snp_retry  <= 1'b0;
      cpu_stall  <= 1'b0;
      co_issue   <= 1'b0;
      fill_issue <= 1'b0;
    end else begin
      tag_en     <= (owner != OWN_IDLE);
      tag_we     <= (owner == OWN_WRITE);
      tag_addr   <= addr_n;
      port_owner <= owner;
      snp_grant  <= snp_ok;
      snp_retry  <= snp_rej;
      cpu_stall  <= cpu_req && !cpu_win;
      co_issue   <= co_go;
      fill_issue <= fill_go;
    end
  end

  assign cob_full   = cob_valid;
  assign cob_urgent = cob_hot;

  // R8: the two snoop answers exclude each other
  a_r8_one_answer: assert property (@(posedge clk) disable iff (rst)
    !(snp_grant && snp_retry));
  // R3: a snoop that meets a tag write is retried
  a_r3_write_retries: assert property (@(posedge clk) disable iff (rst)
    (snp_req && twr_req) |=> snp_retry);
  // R4: a snoop during a burst is retried
  a_r4_burst_retries: assert property (@(posedge clk) disable iff (rst)
    (snp_req && burst_busy) |=> snp_retry);
  // R7: a tag write owns the port and stalls the processor
  a_r7_write_wins: assert property (@(posedge clk) disable iff (rst)
    (twr_req && cpu_req) |=> (tag_we && cpu_stall));
  // R2: a stalled processor request is served next if no write interferes
  a_r2_cpu_next: assert property (@(posedge clk) disable iff (rst)
    (cpu_stall && cpu_req && !twr_req) |=> (port_owner == 2'd3));
  // R6: one bus issue per cycle
  a_r6_single_issue: assert property (@(posedge clk) disable iff (rst)
    !(co_issue && fill_issue));
endmodule

// File: tb/tag_port_arbiter_tb.sv
module tag_port_arbiter_tb;
  logic        clk = 0, rst = 1;
  logic        cpu_req = 0, snp_req = 0, twr_req = 0, burst_busy = 0;
  logic        cob_load = 0, fill_pend = 0, bus_ready = 0;
  logic [31:0] cpu_addr = 0, snp_addr = 0, twr_addr = 0;
  logic [26:0] cob_blk = 0;
  logic        tag_en, tag_we, snp_grant, snp_retry, cpu_stall;
  logic        cob_full, cob_urgent, co_issue, fill_issue;
  logic [31:0] tag_addr;
  logic [1:0]  port_owner;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  tag_port_arbiter u_dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .snp_req(snp_req), .snp_addr(snp_addr), .twr_req(twr_req),
    .twr_addr(twr_addr), .burst_busy(burst_busy), .cob_load(cob_load),
    .cob_blk(cob_blk), .fill_pend(fill_pend), .bus_ready(bus_ready),
    .tag_en(tag_en), .tag_we(tag_we), .tag_addr(tag_addr),
    .port_owner(port_owner), .snp_grant(snp_grant), .snp_retry(snp_retry),
    .cpu_stall(cpu_stall), .cob_full(cob_full), .cob_urgent(cob_urgent),
    .co_issue(co_issue), .fill_issue(fill_issue)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    cpu_req = 0; snp_req = 0; twr_req = 0; burst_busy = 0;
    cob_load = 0; fill_pend = 0; bus_ready = 0;
  endtask

  task automatic t_reset();
    chk("R9 owner", port_owner, 0); chk("R9 grant", snp_grant, 0);
    chk("R9 retry", snp_retry, 0); chk("R9 stall", cpu_stall, 0);
    chk("R9 tag_en", tag_en, 0); chk("R9 cob", cob_full, 0);
    chk("R9 issue", {co_issue, fill_issue}, 0);
  endtask

  task automatic t_snoop_wins();
    snp_req = 1; snp_addr = 32'h0000_1040; cpu_req = 1; cpu_addr = 32'h0000_2000;
    step();
    chk("R1 grant", snp_grant, 1); chk("R1 owner", port_owner, 2);
    chk("R1 addr", tag_addr, 32'h0000_1040); chk("R1 stall", cpu_stall, 1);
    // R2: processor owed, new snoop retried
    snp_addr = 32'h0000_3000;
    step();
    chk("R2 owner", port_owner, 3); chk("R2 addr", tag_addr, 32'h0000_2000);
    chk("R2 retry", snp_retry, 1); chk("R2 no stall", cpu_stall, 0);
    idle(); step();
    chk("R8 pulse", {snp_grant, snp_retry}, 0);
  endtask

  task automatic t_tag_write();
    twr_req = 1; twr_addr = 32'h0000_5500; snp_req = 1; snp_addr = 32'h0000_7700;
    cpu_req = 1;
    step();
    chk("R3 owner", port_owner, 1); chk("R3 we", tag_we, 1);
    chk("R3 addr", tag_addr, 32'h0000_5500); chk("R3 retry", snp_retry, 1);
    chk("R7 stall", cpu_stall, 1);
    // R8: retry kept no state: same snoop granted when the write is gone
    twr_req = 0; cpu_req = 0;
    step();
    chk("R8 regrant", snp_grant, 1); chk("R8 no retry", snp_retry, 0);
    idle(); step();
  endtask

  task automatic t_burst();
    burst_busy = 1; snp_req = 1; snp_addr = 32'h0000_8000;
    cpu_req = 1; cpu_addr = 32'h0000_9000;
    step();
    chk("R4 retry", snp_retry, 1); chk("R4 owner", port_owner, 3);
    chk("R4 addr", tag_addr, 32'h0000_9000); chk("R4 stall", cpu_stall, 0);
    idle(); step();
  endtask

  task automatic t_collision();
    cob_load = 1; cob_blk = 27'h00_0123;
    step(); cob_load = 0;
    chk("R10 full", cob_full, 1); chk("R10 not urgent", cob_urgent, 0);
    snp_req = 1; snp_addr = {27'h00_0124, 5'h04};
    step();
    chk("R10 other block granted", snp_grant, 1); chk("R10 urgent", cob_urgent, 0);
    snp_addr = {27'h00_0123, 5'h1c};
    step();
    chk("R5 retry", snp_retry, 1); chk("R5 urgent", cob_urgent, 1);
    snp_req = 0; fill_pend = 1; bus_ready = 1;
    step();
    chk("R6 urgent castout first", co_issue, 1); chk("R6 fill held", fill_issue, 0);
    chk("R6 cob empty", cob_full, 0); chk("R6 urgency cleared", cob_urgent, 0);
    step();
    chk("R6 fill next", fill_issue, 1); chk("R6 no castout", co_issue, 0);
    idle(); step();
  endtask

  task automatic t_normal_order();
    cob_load = 1; cob_blk = 27'h00_0456;
    step(); cob_load = 0;
    fill_pend = 1; bus_ready = 1;
    step();
    chk("R6 fill before normal castout", fill_issue, 1); chk("R6 castout waits", co_issue, 0);
    fill_pend = 0;
    step();
    chk("R6 normal castout", co_issue, 1); chk("R6 buffer drained", cob_full, 0);
    bus_ready = 0;
    idle(); step();
  endtask

  initial begin
    repeat (3) step();
    rst = 0; #0;
    t_reset();
    t_snoop_wins();
    t_tag_write();
    t_burst();
    t_collision();
    t_normal_order();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule